// File: doc/BRIEF.md
# Serial Baud Tick Source Selector

This block generates the 16x oversampling tick enable that paces a serial transceiver. Three rate sources feed it. The first is a dedicated down-counter on the oscillator clock, loaded with a 16-bit divisor. The second is an overflow pulse from an external timer, which is halved unless the rate-doubling input is set. The third is a fixed fraction of the oscillator clock.

The serial mode input and a source-select bit choose the source. The fixed-rate 11-bit mode always uses the clock fraction. The 10-bit mode and the variable 11-bit mode use either the timer overflow or the dedicated counter. The synchronous shift mode gets no tick from this block.

Software loads the divisor one byte at a time through two write strobes that share one data bus. The counter adopts the new value only after both bytes have arrived. When the source selection changes, the prescale state restarts, so no shortened first period reaches the transceiver.

Top module: `bgen_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `tick` is 0. Reset clears the active divisor to 0, the halving phase and the fixed-fraction phase.
- R2: `ser_mode` is 1 (10-bit) or 3 (variable 11-bit), `src_sel` is 1 and the active divisor D is at least 2. In this case `tick` pulses for one cycle every D clock cycles. The first pulse is seen D clock edges after the edge that completes a divisor load.
- R3: `div_lo_wr` captures `div_wdata` as bits 7:0 of the divisor and `div_hi_wr` captures it as bits 15:8. The halves may be written in either order. The active divisor changes only on the write that completes the pair. A lone half write leaves the tick period unchanged.
- R4: While the active divisor is 0 or 1, the dedicated source produces no tick.
- R5: In modes 1 and 3 with `src_sel` 0, a tick follows an `ovf_pulse` by one cycle. With `dbl_rate` 1 every overflow gives a tick. With `dbl_rate` 0 only every second overflow does, starting with the second one after a restart.
- R6: In mode 2 (fixed 11-bit), `tick` pulses once every 16 clocks when `dbl_rate` is 1 and once every 32 clocks when it is 0. `ovf_pulse`, the divisor and `src_sel` have no effect on it.
- R7: In mode 0 (shift mode), `tick` stays 0.
- R8: A change of `src_sel` suppresses any tick of the variable paths for that cycle. It restarts the dedicated counter from the full divisor and returns the overflow halver to its first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_pulse | input | 1 | Single-cycle overflow pulse from the external timer |
| div_lo_wr | input | 1 | Write strobe for the low divisor byte |
| div_hi_wr | input | 1 | Write strobe for the high divisor byte |
| div_wdata | input | 8 | Divisor byte data |
| src_sel | input | 1 | 0 selects timer overflow, 1 selects the dedicated counter |
| dbl_rate | input | 1 | Rate-doubling control |
| ser_mode | input | 2 | Serial mode: 0 shift, 1 10-bit, 2 fixed 11-bit, 3 variable 11-bit |
| tick | output | 1 | Single-cycle 16x baud tick enable |

## Verification
The bench uses the default parameters: 8-bit halves forming a 16-bit divisor, and fixed fractions of 16 and 32. Random divisors are mostly kept below 300. With periods that short, many complete periods fit in every segment, along with partial half-writes, select toggles mid-period and changes of the doubling bit. A directed load of 258 sets a non-zero high byte. The divisor values 0 and 1 and both write orders are exercised on purpose.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    typedef enum logic [1:0] {
        SM_SHIFT   = 2'd0,
        SM_TEN     = 2'd1,
        SM_ELV_FIX = 2'd2,
        SM_ELV_VAR = 2'd3
    } ser_mode_e;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_TIMER,
        PATH_DEDIC,
        PATH_FIXED
    } path_e;

    typedef struct packed {
        logic lo_seen;
        logic hi_seen;
    } half_flags_t;

    function automatic path_e pick_path(input logic [1:0] mode, input logic sel);
        case (ser_mode_e'(mode))
            SM_TEN, SM_ELV_VAR: return sel ? PATH_DEDIC : PATH_TIMER;
            SM_ELV_FIX:         return PATH_FIXED;
            default:            return PATH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bgen_div_regs.sv
module bgen_div_regs #(
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   div_act,
    output logic [2*HALF_W-1:0]   div_next,
    output logic                  commit
);
    import bgen_pkg::*;

    logic [HALF_W-1:0] lo_stage, hi_stage;
    half_flags_t       flags;
    half_flags_t       flags_now;

    always_comb begin
        flags_now.lo_seen = flags.lo_seen | wr_lo;
        flags_now.hi_seen = flags.hi_seen | wr_hi;
        commit   = (wr_lo | wr_hi) & flags_now.lo_seen & flags_now.hi_seen;
        div_next = {(wr_hi ? wdata : hi_stage), (wr_lo ? wdata : lo_stage)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_stage <= '0;
            hi_stage <= '0;
            flags    <= '0;
            div_act  <= '0;
        end else if (commit) begin
            div_act  <= div_next;
            flags    <= '0;
        end else begin
            if (wr_lo) begin
                lo_stage      <= wdata;
                flags.lo_seen <= 1'b1;
            end
            if (wr_hi) begin
                hi_stage      <= wdata;
                flags.hi_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bgen_ded_cnt.sv
module bgen_ded_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_act,
    input  logic [DIV_W-1:0] div_next,
    input  logic             commit,
    input  logic             restart,
    output logic             fire
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    function automatic logic [DIV_W-1:0] reload(input logic [DIV_W-1:0] d);
        return (d > ONE) ? d - ONE : '0;
    endfunction

    assign fire = (cnt == '0) && (div_act > ONE);

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (commit)       cnt <= reload(div_next);
        else if (restart)      cnt <= reload(div_act);
        else if (fire)         cnt <= reload(div_act);
        else if (cnt != '0)    cnt <= cnt - ONE;
    end
endmodule

// File: rtl/bgen_ovf_half.sv
module bgen_ovf_half (
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    input  logic dbl,
    input  logic restart,
    output logic fire
);
    logic phase;

    assign fire = ovf & (dbl | phase);

    always_ff @(posedge clk) begin
        if (rst || restart)   phase <= 1'b0;
        else if (ovf && !dbl) phase <= ~phase;
    end
endmodule

// File: rtl/bgen_fix_div.sv
module bgen_fix_div #(
    parameter int SLOW = 32,
    parameter int FAST = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic dbl,
    output logic fire
);
    localparam int CW = $clog2(SLOW);
    localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(FAST - 1);

    logic [CW-1:0] cnt;

    assign fire = cnt >= (dbl ? LIM_FAST : LIM_SLOW);

    always_ff @(posedge clk) begin
        if (rst || fire) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bgen_top.sv
module bgen_top #(
    parameter int HALF_W   = 8,
    parameter int FIX_SLOW = 32,
    parameter int FIX_FAST = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ovf_pulse,
    input  logic              div_lo_wr,
    input  logic              div_hi_wr,
    input  logic [HALF_W-1:0] div_wdata,
    input  logic              src_sel,
    input  logic              dbl_rate,
    input  logic [1:0]        ser_mode,
    output logic              tick
);
    import bgen_pkg::*;

    localparam int DIV_W = 2 * HALF_W;

    logic [DIV_W-1:0] div_act, div_next;
    logic             commit, sel_q, restart;
    logic             ded_fire, tmr_fire, fix_fire, tick_d;
    path_e            path;

    assign restart = (src_sel != sel_q);
    assign path    = pick_path(ser_mode, src_sel);

    bgen_div_regs #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst(rst), .wr_lo(div_lo_wr), .wr_hi(div_hi_wr),
        .wdata(div_wdata), .div_act(div_act), .div_next(div_next), .commit(commit)
    );

    bgen_ded_cnt #(.DIV_W(DIV_W)) u_ded (
        .clk(clk), .rst(rst), .div_act(div_act), .div_next(div_next),
        .commit(commit), .restart(restart), .fire(ded_fire)
    );

    bgen_ovf_half u_half (
        .clk(clk), .rst(rst), .ovf(ovf_pulse), .dbl(dbl_rate),
        .restart(restart), .fire(tmr_fire)
    );

    bgen_fix_div #(.SLOW(FIX_SLOW), .FAST(FIX_FAST)) u_fix (
        .clk(clk), .rst(rst), .dbl(dbl_rate), .fire(fix_fire)
    );

    always_comb begin
        case (path)
            PATH_DEDIC: tick_d = ded_fire & ~restart;
            PATH_TIMER: tick_d = tmr_fire & ~restart;
            PATH_FIXED: tick_d = fix_fire;
            default:    tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        sel_q <= src_sel;
        if (rst) tick <= 1'b0;
        else     tick <= tick_d;
    end
endmodule

// File: rtl/bgen_chk.sv
module bgen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ovf_pulse,
    input logic             src_sel,
    input logic             dbl_rate,
    input logic [1:0]       ser_mode,
    input logic             tick,
    input logic [DIV_W-1:0] div_act
);
    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tick);

    // R7: shift mode never ticks
    p_shift_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (ser_mode == 2'd0) |=> !tick);

    // R4: divisor 0 or 1 keeps the dedicated path silent
    p_small_div_r4: assert property (@(posedge clk) disable iff (rst)
        (ser_mode[0] && src_sel && div_act <= DIV_W'(1)) |=> !tick);

    // R5: timer path only ticks after an overflow
    p_ovf_only_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_mode[0] && !src_sel && !ovf_pulse) |=> !tick);

    // R5: without doubling, two overflows in a row cannot both tick
    p_ovf_halved_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_mode[0] && !src_sel && $stable(src_sel) && !dbl_rate && tick
         && ovf_pulse && $stable(dbl_rate)) |=> !tick);

    // R6: fixed path ticks are single-cycle
    p_fix_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (ser_mode == 2'd2 && tick && $past(ser_mode) == 2'd2) |=> !tick);

    // R8: a select change suppresses the variable-path tick
    p_sel_change_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_mode[0] && src_sel != $past(src_sel)) |=> !tick);
endmodule

bind bgen_top bgen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .ovf_pulse(ovf_pulse), .src_sel(src_sel),
    .dbl_rate(dbl_rate), .ser_mode(ser_mode), .tick(tick), .div_act(div_act)
);

// File: tb/sim_bgen_top.sv
module sim_bgen_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf = 1'b0, wlo = 1'b0, whi = 1'b0, sel = 1'b0, dbl = 1'b0;
    logic [7:0] wd = '0;
    logic [1:0] mode = 2'd0;
    logic       tick;

    always #5 clk = ~clk;

    bgen_top u0 (
        .clk(clk), .rst(rst), .ovf_pulse(ovf), .div_lo_wr(wlo), .div_hi_wr(whi),
        .div_wdata(wd), .src_sel(sel), .dbl_rate(dbl), .ser_mode(mode), .tick(tick)
    );

    int    checks = 0, failures = 0;
    bit    done = 0;
    string tag_ovr = "";

    // Reference model: phase counters counting up from each restart point
    logic [7:0]  m_lo_s, m_hi_s;
    logic [15:0] m_div;
    int          m_dph, m_fph;
    bit          m_lo_f, m_hi_f, m_par, m_sel, m_tick;
    string       m_tag = "R1";

    function automatic string pick_tag(input logic [1:0] md, input bit s,
                                       input bit rs, input logic [15:0] d);
        if (md == 2'd0) return "R7";
        if (md == 2'd2) return "R6";
        if (rs)         return "R8";
        if (s)          return (d > 16'd1) ? "R2" : "R4";
        return "R5";
    endfunction

    always @(posedge clk) begin : model
        bit restart, fd, ft, ff, commit, lo_now, hi_now;
        logic [15:0] nd, old_div;
        if (rst) begin
            m_lo_s = '0; m_hi_s = '0; m_div = '0; m_dph = 0; m_fph = 0;
            m_lo_f = 0; m_hi_f = 0; m_par = 0; m_sel = sel; m_tick = 0;
            m_tag = "R1";
        end else begin
            restart = (sel != m_sel);
            old_div = m_div;
            fd = (m_div > 16'd1) && (m_dph == int'(m_div) - 1);
            ft = ovf && (dbl || m_par);
            ff = m_fph >= (dbl ? 15 : 31);
            case (mode)
                2'd1, 2'd3: m_tick = (sel ? fd : ft) && !restart;
                2'd2:       m_tick = ff;
                default:    m_tick = 0;
            endcase
            m_tag = (tag_ovr != "") ? tag_ovr : pick_tag(mode, sel, restart, m_div);
            lo_now = m_lo_f || wlo;
            hi_now = m_hi_f || whi;
            commit = (wlo || whi) && lo_now && hi_now;
            nd = {(whi ? wd : m_hi_s), (wlo ? wd : m_lo_s)};
            if (commit) begin
                m_div = nd; m_lo_f = 0; m_hi_f = 0;
            end else begin
                if (wlo) begin m_lo_s = wd; m_lo_f = 1; end
                if (whi) begin m_hi_s = wd; m_hi_f = 1; end
            end
            if (commit || restart || fd || old_div <= 16'd1) m_dph = 0;
            else                                             m_dph = m_dph + 1;
            if (restart)           m_par = 0;
            else if (ovf && !dbl)  m_par = ~m_par;
            m_fph = ff ? 0 : m_fph + 1;
            m_sel = sel;
        end
    end

    task automatic check_tick();
        checks++;
        if (tick !== m_tick) begin
            failures++;
            $display("FAIL %s tick actual=%0b expected=%0b at %0t", m_tag, tick, m_tick, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_tick();
    endtask

    task automatic run(input int n, input int ovf_gap);
        for (int i = 0; i < n; i++) begin
            ovf = (ovf_gap > 0) ? (i % ovf_gap == 0) : 1'b0;
            step();
        end
        ovf = 1'b0;
    endtask

    task automatic wr(input bit hi, input logic [7:0] v);
        wd = v; wlo = !hi; whi = hi;
        step();
        wlo = 0; whi = 0;
    endtask

    task automatic load(input logic [15:0] d, input bit hi_first);
        if (hi_first) begin wr(1, d[15:8]); wr(0, d[7:0]); end
        else          begin wr(0, d[7:0]);  wr(1, d[15:8]); end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step();
        rst = 0;
        step();
        // R2: dedicated period 5
        mode = 2'd1; sel = 1;
        load(16'd5, 0);
        run(40, 0);
        // R3: lone low write keeps period, pair completes in either order
        tag_ovr = "R3";
        wr(0, 8'd9);
        run(30, 0);
        wr(1, 8'd0);
        run(40, 0);
        load(16'h0102, 1);
        run(600, 0);
        tag_ovr = "";
        // R4: divisor 1 and 0
        load(16'd1, 0); run(40, 0);
        load(16'd0, 1); run(40, 0);
        // R8: select toggles mid-period
        load(16'd7, 0); run(10, 0);
        sel = 0; run(5, 2);
        sel = 1; run(30, 3);
        // R5: timer path halved and doubled
        mode = 2'd3; sel = 0; dbl = 0; run(60, 3);
        dbl = 1; run(40, 4);
        // R6: fixed mode both rates, with other inputs moving
        mode = 2'd2; dbl = 1; run(70, 2);
        sel = 1; load(16'd3, 0);
        dbl = 0; run(100, 5);
        // R7: shift mode
        mode = 2'd0; run(40, 1);
        // Random segments
        for (int s = 0; s < 80; s++) begin
            int r;
            r = $urandom_range(0, 9);
            mode = (r < 1) ? 2'd0 : (r < 3) ? 2'd2 : (r < 6) ? 2'd1 : 2'd3;
            if ($urandom_range(0, 2) == 0) sel = ~sel;
            dbl = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0) begin
                logic [7:0] lo_v, hi_v;
                lo_v = 8'($urandom_range(0, 40));
                hi_v = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0;
                if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 1), lo_v);
                else                           load({hi_v, lo_v}, $urandom_range(0, 1));
            end
            for (int i = 0; i < int'($urandom_range(30, 150)); i++) begin
                ovf = ($urandom_range(0, 3) == 0);
                step();
            end
            ovf = 0;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule